// File: doc/BRIEF.md
# Confidence-Windowed Wake Trigger

This block sits between an inference engine and a sleeping host processor. The engine delivers one 8-bit confidence score per processed frame, together with a strobe. Each score is compared with a programmable threshold, and a frame whose score lies strictly above it is recorded as a hit. The block keeps the hit bits of the most recent N frames in a sliding window. It raises a level interrupt to the host only when at least K of those N frames were hits. A single noise spike therefore cannot wake the host, while a sustained match will.

Once raised, the interrupt stays high until the host pulses the clear input. The clear also empties the window, so the burst that caused the wake cannot immediately fire again. A sticky detection flag records that a detection occurred at least once since reset. The current number of hits in the window is exposed for observation. When the enable input is low, the block holds the interrupt low, empties the window and ignores incoming frames.

Top module: `wake_trigger`

## Requirements
- R1: After a synchronous reset, `irq_o`, `detect_flag_o` and `hit_count_o` are all 0.
- R2: An accepted frame is a hit only when `score_i` is strictly greater than `thresh_i`, both read as unsigned 8-bit values where 255 is full confidence. A score equal to the threshold is not a hit. After the clock edge that accepts a frame, `hit_count_o` equals the number of hits among the last N accepted frames.
- R3: The window length is `win_n_i`, with 0 treated as 1 and any value above 8 treated as 8. A hit stops counting once N newer frames have been accepted.
- R4: The effective K is `need_k_i`, with 0 treated as 1. `irq_o` rises at the same clock edge that accepts a frame which makes the new hit count reach the effective K or more.
- R5: When the effective K exceeds the effective N, `irq_o` never rises, however many hits arrive.
- R6: Once high, `irq_o` stays high until `irq_clr_i` is sampled high. That edge drives `irq_o` low and sets the hit count to 0. A frame strobed in the same cycle as the clear is dropped.
- R7: While `enable_i` is low, `irq_o` is 0, the hit count is 0, and strobed frames leave no trace once enable returns.
- R8: `detect_flag_o` goes high at the edge where `irq_o` rises, and only reset clears it. Clear and disable leave it unchanged.
- R9: In cycles without `score_vld_i`, `hit_count_o` and `irq_o` keep their values. A stream of scores at or below the threshold never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| score_i | input | 8 | Confidence score of the current frame |
| score_vld_i | input | 1 | Strobe: `score_i` carries a new frame |
| thresh_i | input | 8 | Hit threshold; the score must be strictly above it |
| need_k_i | input | 4 | Number of hits needed to fire (0 acts as 1) |
| win_n_i | input | 4 | Window length in frames (0 acts as 1; above 8 acts as 8) |
| enable_i | input | 1 | Low holds the interrupt low and empties the window |
| irq_clr_i | input | 1 | Host clear pulse for the interrupt; it also empties the window |
| irq_o | output | 1 | Level interrupt to the host |
| detect_flag_o | output | 1 | Sticky record that a detection occurred |
| hit_count_o | output | 4 | Number of hits currently in the window |

## Verification
All three outputs are registered. A frame, clear or disable sampled at a rising edge therefore shows its effect on `hit_count_o`, `irq_o` and `detect_flag_o` immediately after that same edge, with no added latency. The bench drives every input at the falling edge. It updates its expected window at the following rising edge and compares all three outputs at the next falling edge, one full cycle after the stimulus was applied. Idle cycles are compared in the same way, which confirms that nothing moves without a strobe.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // Population count of a hit vector; callers zero-extend narrower windows.
  function automatic int unsigned count_ones(input logic [31:0] v);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < 32; i++) begin
      acc = acc + int'(v[i]);
    end
    return acc;
  endfunction

endpackage

// File: rtl/wt_hit_cmp.sv
module wt_hit_cmp #(
  parameter int SCORE_W = 8
) (
  input  logic [SCORE_W-1:0] score,
  input  logic [SCORE_W-1:0] thresh,
  output logic               hit
);
  // Strict comparison: a score equal to the threshold does not qualify.
  assign hit = (score > thresh);
endmodule

// File: rtl/wt_window.sv
module wt_window
  import wt_pkg::*;
#(
  parameter int WIN_MAX = 8,
  parameter int CNT_W   = $clog2(WIN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             shift,
  input  logic             hit_in,
  input  logic [CNT_W-1:0] n_eff,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_next
);
  logic [WIN_MAX-1:0] win_q, win_d, len_mask;

  always_comb begin
    for (int i = 0; i < WIN_MAX; i++) begin
      len_mask[i] = (i < int'(n_eff));
    end
  end

  always_comb begin
    win_d = win_q;
    if (flush) begin
      win_d = '0;
    end else if (shift) begin
      win_d = {win_q[WIN_MAX-2:0], hit_in} & len_mask;
    end
  end

  assign count_next = CNT_W'(count_ones(32'(win_d)));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= '0;
      count_q <= '0;
    end else begin
      win_q   <= win_d;
      count_q <= count_next;
    end
  end

  // R3: after a shift the count never exceeds the window length in force
  a_r3_count_within_n: assert property (@(posedge clk) disable iff (rst)
    (shift && !flush) |=> (count_q <= $past(n_eff)));

  // R6/R7: a flush leaves an empty window
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count_q == '0));

endmodule

// File: rtl/wt_fire_ctl.sv
module wt_fire_ctl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             clr,
  input  logic             frame,
  input  logic [CNT_W-1:0] count_next,
  input  logic [CNT_W-1:0] k_raw,
  input  logic [CNT_W-1:0] n_eff,
  output logic             irq_q,
  output logic             flag_q
);
  logic [CNT_W-1:0] k_eff;
  logic             reachable;

  assign k_eff     = (k_raw == '0) ? CNT_W'(1) : k_raw;
  assign reachable = (k_eff <= n_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (!enable || clr) begin
      irq_q  <= 1'b0;
    end else if (frame && reachable && (count_next >= k_eff)) begin
      irq_q  <= 1'b1;
      flag_q <= 1'b1;
    end
  end

  // R4: the interrupt only rises at an edge that accepted a frame
  a_r4_rise_on_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(frame));

  // R5: an unreachable K keeps a low interrupt low
  a_r5_unreachable_silent: assert property (@(posedge clk) disable iff (rst)
    (enable && !clr && !irq_q && (k_raw > n_eff)) |=> !irq_q);

  // R7: disable forces the interrupt low
  a_r7_disable_low: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !irq_q);

  // R8: the detection flag is sticky
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    flag_q |=> flag_q);

endmodule

// File: rtl/wake_trigger.sv
module wake_trigger #(
  parameter int SCORE_W = 8,
  parameter int WIN_MAX = 8,
  parameter int CNT_W   = $clog2(WIN_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SCORE_W-1:0] score_i,
  input  logic               score_vld_i,
  input  logic [SCORE_W-1:0] thresh_i,
  input  logic [CNT_W-1:0]   need_k_i,
  input  logic [CNT_W-1:0]   win_n_i,
  input  logic               enable_i,
  input  logic               irq_clr_i,
  output logic               irq_o,
  output logic               detect_flag_o,
  output logic [CNT_W-1:0]   hit_count_o
);
  logic             hit;
  logic             flush;
  logic             frame;
  logic [CNT_W-1:0] n_eff;
  logic [CNT_W-1:0] count_next;

  assign n_eff = (win_n_i == '0)               ? CNT_W'(1) :
                 (win_n_i > CNT_W'(WIN_MAX))   ? CNT_W'(WIN_MAX) : win_n_i;
  assign flush = !enable_i || irq_clr_i;
  assign frame = enable_i && score_vld_i && !irq_clr_i;

  wt_hit_cmp #(.SCORE_W(SCORE_W)) u_cmp (
    .score  (score_i),
    .thresh (thresh_i),
    .hit    (hit)
  );

  wt_window #(.WIN_MAX(WIN_MAX), .CNT_W(CNT_W)) u_win (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .shift      (frame),
    .hit_in     (hit),
    .n_eff      (n_eff),
    .count_q    (hit_count_o),
    .count_next (count_next)
  );

  wt_fire_ctl #(.CNT_W(CNT_W)) u_fire (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable_i),
    .clr        (irq_clr_i),
    .frame      (frame),
    .count_next (count_next),
    .k_raw      (need_k_i),
    .n_eff      (n_eff),
    .irq_q      (irq_o),
    .flag_q     (detect_flag_o)
  );

  // R9: idle cycles change nothing
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (enable_i && !irq_clr_i && !score_vld_i) |=> ($stable(hit_count_o) && $stable(irq_o)));

  // R6: a clear drops the interrupt and empties the count
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
    irq_clr_i |=> (!irq_o && hit_count_o == '0));

endmodule

// File: tb/wake_trigger_tb.sv
module wake_trigger_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] score_i = '0;
  logic       score_vld_i = 1'b0;
  logic [7:0] thresh_i = 8'd217;
  logic [3:0] need_k_i = 4'd3;
  logic [3:0] win_n_i = 4'd5;
  logic       enable_i = 1'b0;
  logic       irq_clr_i = 1'b0;
  logic       irq_o, detect_flag_o;
  logic [3:0] hit_count_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_win = '0;
  bit m_irq = 0;
  bit m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_trigger u_dut (
    .clk(clk), .rst(rst), .score_i(score_i), .score_vld_i(score_vld_i),
    .thresh_i(thresh_i), .need_k_i(need_k_i), .win_n_i(win_n_i),
    .enable_i(enable_i), .irq_clr_i(irq_clr_i), .irq_o(irq_o),
    .detect_flag_o(detect_flag_o), .hit_count_o(hit_count_o)
  );

  function automatic int eff_n(input int n);
    return (n == 0) ? 1 : ((n > 8) ? 8 : n);
  endfunction

  function automatic int eff_k(input int k);
    return (k == 0) ? 1 : k;
  endfunction

  function automatic int pop8(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected state after one rising edge with the current inputs.
  task automatic model_edge();
    int n, k;
    n = eff_n(int'(win_n_i));
    k = eff_k(int'(need_k_i));
    if (!enable_i || irq_clr_i) begin
      m_win = '0;
      m_irq = 0;
    end else if (score_vld_i) begin
      m_win = ((m_win << 1) | 8'(score_i > thresh_i)) & 8'((1 << n) - 1);
      if (k <= n && pop8(m_win) >= k) begin
        m_irq = 1;
        m_flag = 1;
      end
    end
  endtask

  // Called at a falling edge: apply inputs, cross one rising edge, compare.
  task automatic cyc(input string tag, input bit vld, input int sc, input bit clr);
    score_vld_i = vld;
    score_i = 8'(sc);
    irq_clr_i = clr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "hit_count", int'(hit_count_o), pop8(m_win));
    chk(tag, "irq", int'(irq_o), int'(m_irq));
    chk(tag, "flag", int'(detect_flag_o), int'(m_flag));
    score_vld_i = 0;
    irq_clr_i = 0;
  endtask

  task automatic config_set(input int n, input int k);
    enable_i = 0;
    cyc("R7", 0, 0, 0);
    win_n_i = 4'(n);
    need_k_i = 4'(k);
    enable_i = 1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "irq", int'(irq_o), 0);
    chk("R1", "flag", int'(detect_flag_o), 0);
    chk("R1", "hit_count", int'(hit_count_o), 0);
    rst = 0;
    config_set(5, 3);

    // R2: equal to threshold is no hit; R9: low scores never fire
    for (int i = 0; i < 6; i++) cyc("R9", 1, 217, 0);
    chk("R2", "equal_not_hit", int'(hit_count_o), 0);
    cyc("R2", 1, 218, 0);
    chk("R2", "one_hit", int'(hit_count_o), 1);
    // R9: idle cycles hold the count
    for (int i = 0; i < 4; i++) cyc("R9", 0, 255, 0);
    chk("R9", "idle_hold", int'(hit_count_o), 1);
    // R4: 3 of 5 fires on the third hit
    cyc("R4", 1, 10, 0);
    cyc("R4", 1, 250, 0);
    chk("R4", "not_yet", int'(irq_o), 0);
    cyc("R4", 1, 240, 0);
    chk("R4", "fired", int'(irq_o), 1);
    chk("R8", "flag_set", int'(detect_flag_o), 1);
    // R6: held until clear, clear beats a frame in the same cycle
    for (int i = 0; i < 5; i++) cyc("R6", 1, 0, 0);
    chk("R6", "held", int'(irq_o), 1);
    cyc("R6", 1, 255, 1);
    chk("R6", "cleared", int'(irq_o), 0);
    chk("R6", "flushed", int'(hit_count_o), 0);
    chk("R8", "flag_after_clear", int'(detect_flag_o), 1);

    // R3: hits age out after N frames (N=2, K=2)
    config_set(2, 2);
    cyc("R3", 1, 255, 0);
    cyc("R3", 1, 0, 0);
    cyc("R3", 1, 255, 0);
    chk("R3", "aged_out", int'(irq_o), 0);
    // R3: N above 8 clamps to 8, K=8 needs eight hits
    config_set(12, 8);
    for (int i = 0; i < 7; i++) cyc("R3", 1, 255, 0);
    chk("R3", "seven_of_eight", int'(irq_o), 0);
    cyc("R3", 1, 255, 0);
    chk("R3", "eight_fires", int'(irq_o), 1);
    // R4: K=0 acts as 1
    config_set(4, 0);
    cyc("R4", 1, 255, 0);
    chk("R4", "k_zero", int'(irq_o), 1);
    // R5: K greater than N never fires
    config_set(5, 6);
    for (int i = 0; i < 10; i++) cyc("R5", 1, 255, 0);
    chk("R5", "unreachable", int'(irq_o), 0);
    // R7: frames while disabled leave no trace
    config_set(3, 1);
    enable_i = 0;
    cyc("R7", 1, 255, 0);
    chk("R7", "disabled_count", int'(hit_count_o), 0);
    enable_i = 1;
    cyc("R7", 1, 0, 0);
    chk("R7", "no_trace", int'(irq_o), 0);

    // Random phase: mixed configs, scores around the threshold
    for (int blk = 0; blk < 40; blk++) begin
      config_set(int'($urandom_range(0, 10)), int'($urandom_range(0, 9)));
      thresh_i = 8'($urandom_range(100, 230));
      for (int c = 0; c < 60; c++) begin
        int sc;
        sc = int'(thresh_i) + int'($urandom_range(0, 40)) - 20;
        if (sc < 0) sc = 0;
        if (sc > 255) sc = 255;
        cyc("R2", ($urandom_range(0, 3) != 0), sc, ($urandom_range(0, 19) == 0));
      end
    end

    finish_run();
  end
endmodule